// File: doc/BRIEF.md
# Power LED Mode Controller

This block drives one power-indicator LED pin. Software writes a byte-wide control register. Its two low bits pick one of four pin behaviours:

- released (output enable low);
- held low;
- a 1 Hz square wave with 50% duty;
- a 0.25 Hz square wave with 50% duty.

A single prescaler divides the system clock down to a half-second tick, and both blink rates are derived from that tick. The system clock frequency is the parameter `CLK_HZ`.

Bit 2 of the register selects a count unit for a separate timer: 0 means seconds and 1 means minutes. The block stores this bit and presents it on its own output. Bits 7:3 are reserved. They are not stored and always read as zero.

A write that changes the mode restarts the blink phase, so every newly selected blinking mode begins with the pin low. A write that keeps the same mode leaves the running waveform undisturbed.

Top module: `led_mode_ctrl`

## Requirements
- R1: With mode field (bits 1:0) = 00, led_oe_o is 0 and led_o is 0.
- R2: With mode field = 01, led_oe_o is 1 and led_o is 0 continuously.
- R3: With mode field = 10, led_oe_o is 1 and led_o is a square wave whose high and low phases each last CLK_HZ/2 clock cycles (1 Hz).
- R4: With mode field = 11, led_oe_o is 1 and led_o is a square wave whose high and low phases each last 2*CLK_HZ clock cycles (0.25 Hz).
- R5: After reset the control register reads 0x00, led_oe_o is 0 and unit_min_o is 0.
- R6: A write with wr_en_i = 1 stores wr_data_i[2:0] at the clock edge. rd_data_o shows the new value from that edge on, and bits 7:3 of rd_data_o always read 0 whatever was written.
- R7: unit_min_o equals the stored bit 2 (0 = seconds, 1 = minutes).
- R8: A write that changes the mode field restarts the phase. led_o is 0 after the write edge and first rises CLK_HZ/2 cycles (mode 10) or 2*CLK_HZ cycles (mode 11) after that edge.
- R9: A write whose mode field equals the stored mode does not disturb the blink phase, even if bit 2 changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, CLK_HZ Hz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| unit_min_o | output | 1 | Count unit select: 1 = minutes, 0 = seconds |
| led_o | output | 1 | LED pin value |
| led_oe_o | output | 1 | LED pin output enable |

## Verification
Every output is registered. The read data, unit bit, output enable and a phase restart all take effect at the clock edge that samples a write. A blink edge falls exactly CLK_HZ/2 or 2*CLK_HZ edges after the write edge that started the phase.

The bench runs with a very small CLK_HZ so that whole periods fit in a short run. After each edge, the driver computes the expected pin, enable and register state from the number of edges since the last mode change, and pushes one item per cycle into a queue. The monitor pops and compares one item at every falling edge, so every comparison lands in the same cycle the design produced it.

// File: rtl/led_pkg.sv
package led_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_LOW  = 2'b01,
    MODE_FAST = 2'b10,
    MODE_SLOW = 2'b11
  } led_mode_e;

  localparam int unsigned REG_W     = 8;
  localparam int unsigned STORED_W  = 3;
  localparam int unsigned SLOW_DIV  = 4;  // half-second ticks per slow toggle
endpackage

// File: rtl/led_ctrl_reg.sv
module led_ctrl_reg
  import led_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output led_mode_e        mode_o,
  output logic             unit_min_o,
  output logic [REG_W-1:0] rd_data_o,
  output logic             restart_o
);
  logic [STORED_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= wr_data_i[STORED_W-1:0];
  end

  assign mode_o     = led_mode_e'(ctrl_q[1:0]);
  assign unit_min_o = ctrl_q[2];
  assign rd_data_o  = {{(REG_W-STORED_W){1'b0}}, ctrl_q};
  // phase restarts only when the mode field actually changes
  assign restart_o  = wr_en_i && (wr_data_i[1:0] != ctrl_q[1:0]);
endmodule

// File: rtl/led_prescaler.sv
module led_prescaler #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned HALF = CLK_HZ / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST) && !clr_i;
endmodule

// File: rtl/led_wave.sv
module led_wave
  import led_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      tick_i,
  input  led_mode_e mode_i,
  output logic      led_o,
  output logic      led_oe_o
);
  localparam int unsigned SW = $clog2(SLOW_DIV);

  logic          blink_q;
  logic [SW-1:0] sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blink_q <= 1'b0;
      sub_q   <= '0;
    end else if (clr_i) begin
      blink_q <= 1'b0;
      sub_q   <= '0;
    end else if (tick_i) begin
      sub_q <= sub_q + 1'b1;
      unique case (mode_i)
        MODE_FAST: blink_q <= ~blink_q;
        MODE_SLOW: if (sub_q == SW'(SLOW_DIV - 1)) blink_q <= ~blink_q;
        default:   blink_q <= 1'b0;
      endcase
    end
  end

  assign led_oe_o = (mode_i != MODE_OFF);
  assign led_o    = mode_i[1] & blink_q;
endmodule

// File: rtl/led_mode_ctrl.sv
module led_mode_ctrl
  import led_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       unit_min_o,
  output logic       led_o,
  output logic       led_oe_o
);
  led_mode_e mode;
  logic      restart;
  logic      tick;

  led_ctrl_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .mode_o     (mode),
    .unit_min_o (unit_min_o),
    .rd_data_o  (rd_data_o),
    .restart_o  (restart)
  );

  led_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .tick_o (tick)
  );

  led_wave u_wave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (restart),
    .tick_i   (tick),
    .mode_i   (mode),
    .led_o    (led_o),
    .led_oe_o (led_oe_o)
  );
endmodule

// File: rtl/led_mode_ctrl_chk.sv
module led_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       unit_min_o,
  input logic       led_o,
  input logic       led_oe_o
);
  p_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[1:0] == 2'b00) |-> (!led_oe_o && !led_o));

  p_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[1:0] == 2'b01) |-> (led_oe_o && !led_o));

  p_blink_oe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[1] |-> led_oe_o);

  p_rsvd_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:3] == 5'd0);

  p_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[2:0] == $past(wr_data_i[2:0])));

  p_unit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_min_o == rd_data_o[2]);

  p_restart_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_data_i[1:0] != rd_data_o[1:0])) |=> !led_o);
endmodule

bind led_mode_ctrl led_mode_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .unit_min_o (unit_min_o),
  .led_o      (led_o),
  .led_oe_o   (led_oe_o)
);

// File: tb/sim_led_mode_ctrl.sv
`timescale 1ns/1ps
module sim_led_mode_ctrl;
  localparam int unsigned CLK_HZ = 8;
  localparam int H = CLK_HZ / 2;

  typedef struct {
    logic       led;
    logic       oe;
    logic [7:0] rd;
    logic       unit;
    string      req;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       unit_min_o, led_o, led_oe_o;

  int vectors = 0;
  int miscompares = 0;
  exp_t q[$];

  logic [1:0] m_mode = 2'b00;
  logic [2:0] m_ctrl = 3'b000;
  int         m_t = 0;

  always #5 clk_i = ~clk_i;

  led_mode_ctrl #(.CLK_HZ(CLK_HZ)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .unit_min_o(unit_min_o), .led_o(led_o), .led_oe_o(led_oe_o)
  );

  task automatic step(input logic we, input logic [7:0] d, input string req);
    exp_t e;
    wr_en_i   = we;
    wr_data_i = d;
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0;
    if (we) begin
      if (d[1:0] != m_mode) m_t = 0; else m_t++;
      m_mode = d[1:0];
      m_ctrl = d[2:0];
    end else m_t++;
    e.oe   = (m_mode != 2'b00);
    e.rd   = {5'd0, m_ctrl};
    e.unit = m_ctrl[2];
    case (m_mode)
      2'b10:   e.led = ((m_t / H) % 2) == 1;
      2'b11:   e.led = ((m_t / (4 * H)) % 2) == 1;
      default: e.led = 1'b0;
    endcase
    e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, req);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i);
      if (q.size() > 0) begin
        e = q.pop_front();
        vectors++;
        if (led_o !== e.led || led_oe_o !== e.oe || rd_data_o !== e.rd || unit_min_o !== e.unit) begin
          miscompares++;
          $display("FAIL %s: led=%b oe=%b rd=%02h unit=%b, expected led=%b oe=%b rd=%02h unit=%b",
                   e.req, led_o, led_oe_o, rd_data_o, unit_min_o, e.led, e.oe, e.rd, e.unit);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #12;
    vectors++;  // R5 reset state
    if (rd_data_o !== 8'h00 || led_oe_o !== 1'b0 || unit_min_o !== 1'b0 || led_o !== 1'b0) begin
      miscompares++;
      $display("FAIL R5: rd=%02h oe=%b unit=%b led=%b, expected 00 0 0 0", rd_data_o, led_oe_o, unit_min_o, led_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(3, "R1 R5 idle after reset");
    step(1'b1, 8'h01, "R2 R6 write low mode");
    idle(6, "R2 held low");
    step(1'b1, 8'h02, "R8 R3 enter fast");
    idle(4 * CLK_HZ, "R3 fast blink");
    step(1'b1, 8'h03, "R8 R4 enter slow");
    idle(5 * CLK_HZ, "R4 slow blink");
    step(1'b1, 8'h07, "R9 R7 same mode, minutes");
    idle(3 * CLK_HZ, "R9 phase kept");
    step(1'b1, 8'hFB, "R6 R9 reserved bits ignored");
    idle(2 * CLK_HZ, "R6 R7 seconds, phase kept");
    step(1'b1, 8'h02, "R8 restart to fast");
    idle(H + 2, "R8 fast first rise");
    step(1'b1, 8'h03, "R8 restart slow from high");
    idle(2 * CLK_HZ + 2, "R8 slow first rise");
    step(1'b1, 8'hF8, "R1 R6 off with reserved set");
    idle(H * 3, "R1 released");
    step(1'b1, 8'h04, "R7 unit bit in off mode");
    idle(3, "R7 minutes off");
    @(negedge clk_i);
    @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule